// File: doc/BRIEF.md
# Immediate-Offset Load/Store Unit

This unit carries out word, halfword and byte memory transfers whose address is a base register value plus an unsigned immediate. Each request gives the transfer direction and size, a flag that says whether the base is the stack pointer or a general register, the register indices, the base value, the offset and, for stores, the data register contents. The unit adds the base and the offset and checks the operands. It then either issues one access on a 32-bit little-endian memory bus with byte enables, or reports an illegal operand or an alignment fault.

The legal offset window depends on both the size and the base. Word offsets run up to 1020 with the stack pointer as base and up to 124 with a general register, in steps of four. Halfword offsets run up to 62 in steps of two, and byte offsets up to 31. Sub-word transfers may not use the stack pointer as base.

Stores put the low byte or low halfword of the data register on the lanes chosen by the address, so the other bytes of the memory word are left as they were. Loads take the addressed lanes from the read word, widen them with zeros and hand them to register write-back. The memory is taken to be a synchronous RAM whose read data arrives a fixed number of cycles after the request.

Top module: `imm_ldst_unit`

## Requirements
- R1: A legal, aligned request seen at a clock edge raises `mem_req` for exactly one cycle after that edge, with `mem_addr` equal to `req_base` plus the zero-extended `req_imm`; an offset of 0 addresses the base itself.
- R2: With `req_sp_base`=1 and size code 2'b10 (word), offsets 0..1020 that are multiples of 4 are accepted; any other offset raises `illegal_op`.
- R3: With `req_sp_base`=0 and size code 2'b10 (word), offsets 0..124 that are multiples of 4 are accepted; any other offset raises `illegal_op`.
- R4: Size code 2'b01 (halfword) accepts even offsets 0..62, and size code 2'b00 (byte) accepts offsets 0..31; a sub-word size with `req_sp_base`=1, or size code 2'b11, raises `illegal_op`.
- R5: `req_rt` must be below 8, and `req_rn` must be below 8 when the base is a general register; otherwise `illegal_op` is raised. `req_rn` is ignored when `req_sp_base`=1.
- R6: If the operands are legal but the address is not a multiple of the transfer size (4, 2 or 1), `align_fault` is raised. `illegal_op` takes priority, so the two are never high together.
- R7: Byte enables are `4'b1111` for a word, `4'b0011` shifted left by 2*`mem_addr[1]` for a halfword, and one bit at position `mem_addr[1:0]` for a byte. Lane i carries bits 8i+7..8i.
- R8: A store puts `req_wdata[7:0]` (byte) or `req_wdata[15:0]` (halfword) on the enabled lanes, so the unselected bytes of the memory word are left unchanged.
- R9: For a load, `mem_rdata` is sampled `RD_LAT` cycles after `mem_req` is seen. One cycle later `wb_valid` is high for one cycle, `wb_reg` equals `req_rt` and `wb_data` holds the addressed byte or halfword zero-extended to 32 bits, or the whole word.
- R10: A request that raises `illegal_op` or `align_fault` issues no `mem_req` and no write-back.
- R11: While `rst` is high, and in the cycle after it, `mem_req`, `wb_valid`, `illegal_op` and `align_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A transfer request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 reserved |
| req_sp_base | input | 1 | Base is the stack pointer |
| req_rt | input | IDX_W (4) | Data register index |
| req_rn | input | IDX_W (4) | Base register index (general base only) |
| req_base | input | ADDR_W (32) | Base register value |
| req_imm | input | IMM_W (10) | Unsigned immediate offset |
| req_wdata | input | DATA_W (32) | Data register value for stores |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W (32) | Byte address of the access |
| mem_be | output | DATA_W/8 (4) | Lane enables |
| mem_wdata | output | DATA_W (32) | Lane-steered store data |
| mem_rdata | input | DATA_W (32) | Read word, valid RD_LAT cycles after a read strobe |
| wb_valid | output | 1 | Load result ready for write-back |
| wb_reg | output | 3 | Destination register index |
| wb_data | output | DATA_W (32) | Zero-extended load result |
| illegal_op | output | 1 | Operand check failed |
| align_fault | output | 1 | Address misaligned for the size |

## Verification
On every cycle the assertions check the following:
- a strobe or a fault only follows a request;
- the strobe and the two fault flags are mutually exclusive;
- the byte-enable pattern always has a legal shape that agrees with the low address bits;
- no word or halfword access goes out misaligned.

The offset window for each size and base pairing, the write-back timing and zero extension, and the preservation of untouched memory bytes depend on the values of a request. Those only the bench's directed scenarios can show: boundary offsets, partial stores into preloaded words and loads of bytes whose top bit is set.

// File: rtl/imm_ldst_pkg.sv
package imm_ldst_pkg;

  // Transfer size codes as they appear on req_size
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

endpackage

// File: rtl/imm_ldst_check.sv
module imm_ldst_check
  import imm_ldst_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int IMM_W        = 10,
  parameter int IDX_W        = 4,
  parameter int LOW_REGS     = 8,
  parameter int LANE_BITS    = 2,
  parameter int SP_WORD_MAX  = 1020,
  parameter int REG_WORD_MAX = 124,
  parameter int HALF_MAX     = 62,
  parameter int BYTE_MAX     = 31
) (
  input  acc_size_e          size,
  input  logic               sp_base,
  input  logic [IDX_W-1:0]   rt,
  input  logic [IDX_W-1:0]   rn,
  input  logic [ADDR_W-1:0]  base,
  input  logic [IMM_W-1:0]   imm,
  output logic [ADDR_W-1:0]  eff_addr,
  output logic               bad_operand,
  output logic               misaligned
);

  localparam logic [IDX_W:0]   IDX_LIM  = (IDX_W+1)'(LOW_REGS);
  localparam logic [IMM_W-1:0] LIM_SPW  = IMM_W'(SP_WORD_MAX);
  localparam logic [IMM_W-1:0] LIM_REGW = IMM_W'(REG_WORD_MAX);
  localparam logic [IMM_W-1:0] LIM_HALF = IMM_W'(HALF_MAX);
  localparam logic [IMM_W-1:0] LIM_BYTE = IMM_W'(BYTE_MAX);

  logic idx_bad;
  logic range_ok;

  assign eff_addr = base + {{(ADDR_W-IMM_W){1'b0}}, imm};

  assign idx_bad = ({1'b0, rt} >= IDX_LIM) ||
                   (!sp_base && ({1'b0, rn} >= IDX_LIM));

  always_comb begin
    range_ok = 1'b0;
    case (size)
      SZ_WORD: range_ok = (imm[LANE_BITS-1:0] == '0) &&
                          (imm <= (sp_base ? LIM_SPW : LIM_REGW));
      SZ_HALF: range_ok = !sp_base && !imm[0] && (imm <= LIM_HALF);
      SZ_BYTE: range_ok = !sp_base && (imm <= LIM_BYTE);
      default: range_ok = 1'b0;
    endcase
  end

  assign bad_operand = idx_bad || !range_ok;

  always_comb begin
    case (size)
      SZ_WORD: misaligned = |eff_addr[LANE_BITS-1:0];
      SZ_HALF: misaligned = eff_addr[0];
      default: misaligned = 1'b0;
    endcase
  end

endmodule

// File: rtl/imm_ldst_steer.sv
module imm_ldst_steer
  import imm_ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  acc_size_e             size,
  input  logic [LANE_BITS-1:0]  off,
  input  logic [DATA_W-1:0]     wdata,
  output logic [LANES-1:0]      be,
  output logic [DATA_W-1:0]     lane_data
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic       l_be;
    logic [7:0] l_dat;

    always_comb begin
      case (size)
        SZ_BYTE: begin
          l_be  = (off == LANE_BITS'(i));
          l_dat = wdata[7:0];
        end
        SZ_HALF: begin
          l_be  = (off[LANE_BITS-1:1] == (LANE_BITS-1)'(i / 2));
          l_dat = wdata[8*(i%2) +: 8];
        end
        default: begin
          l_be  = 1'b1;
          l_dat = wdata[8*i +: 8];
        end
      endcase
    end

    assign be[i]              = l_be;
    assign lane_data[8*i +: 8] = l_dat;
  end

endmodule

// File: rtl/imm_ldst_extract.sv
module imm_ldst_extract
  import imm_ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  acc_size_e             size,
  input  logic [LANE_BITS-1:0]  off,
  input  logic [DATA_W-1:0]     rdata,
  output logic [DATA_W-1:0]     value
);

  logic [DATA_W-1:0] shifted;

  assign shifted = rdata >> {off, 3'b000};

  always_comb begin
    case (size)
      SZ_BYTE: value = {{(DATA_W-8){1'b0}},  shifted[7:0]};
      SZ_HALF: value = {{(DATA_W-16){1'b0}}, shifted[15:0]};
      default: value = rdata;
    endcase
  end

endmodule

// File: rtl/imm_ldst_unit.sv
module imm_ldst_unit
  import imm_ldst_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int IMM_W        = 10,
  parameter int IDX_W        = 4,
  parameter int LOW_REGS     = 8,
  parameter int RD_LAT       = 1,
  parameter int SP_WORD_MAX  = 1020,
  parameter int REG_WORD_MAX = 124,
  parameter int HALF_MAX     = 62,
  parameter int BYTE_MAX     = 31,
  localparam int LANES       = DATA_W / 8,
  localparam int LANE_BITS   = $clog2(LANES),
  localparam int REG_W       = $clog2(LOW_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_store,
  input  logic [1:0]         req_size,
  input  logic               req_sp_base,
  input  logic [IDX_W-1:0]   req_rt,
  input  logic [IDX_W-1:0]   req_rn,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [IMM_W-1:0]   req_imm,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               wb_valid,
  output logic [REG_W-1:0]   wb_reg,
  output logic [DATA_W-1:0]  wb_data,
  output logic               illegal_op,
  output logic               align_fault
);

  typedef struct packed {
    logic                 vld;
    logic [REG_W-1:0]     rd;
    acc_size_e            sz;
    logic [LANE_BITS-1:0] off;
  } ld_meta_t;

  acc_size_e         size_in;
  logic [ADDR_W-1:0] eff_addr;
  logic              bad_operand;
  logic              misaligned;
  logic              go;
  logic [LANES-1:0]  be_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] ld_value;
  ld_meta_t          meta_d;
  ld_meta_t          lat_q [RD_LAT+1];

  assign size_in = acc_size_e'(req_size);

  imm_ldst_check #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .IDX_W(IDX_W), .LOW_REGS(LOW_REGS),
    .LANE_BITS(LANE_BITS), .SP_WORD_MAX(SP_WORD_MAX),
    .REG_WORD_MAX(REG_WORD_MAX), .HALF_MAX(HALF_MAX), .BYTE_MAX(BYTE_MAX)
  ) u_check (
    .size(size_in), .sp_base(req_sp_base), .rt(req_rt), .rn(req_rn),
    .base(req_base), .imm(req_imm), .eff_addr(eff_addr),
    .bad_operand(bad_operand), .misaligned(misaligned)
  );

  imm_ldst_steer #(.DATA_W(DATA_W)) u_steer (
    .size(size_in), .off(eff_addr[LANE_BITS-1:0]), .wdata(req_wdata),
    .be(be_d), .lane_data(wdata_d)
  );

  assign go = req_valid && !bad_operand && !misaligned;

  always_comb begin
    meta_d.vld = go && !req_store;
    meta_d.rd  = req_rt[REG_W-1:0];
    meta_d.sz  = size_in;
    meta_d.off = eff_addr[LANE_BITS-1:0];
  end

  // Issue stage: registered bus strobe and fault flags
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req     <= 1'b0;
      illegal_op  <= 1'b0;
      align_fault <= 1'b0;
    end else begin
      mem_req     <= go;
      illegal_op  <= req_valid && bad_operand;
      align_fault <= req_valid && !bad_operand && misaligned;
    end
  end

  // Bus payload carries no reset
  always_ff @(posedge clk) begin
    mem_we    <= req_store;
    mem_addr  <= eff_addr;
    mem_be    <= be_d;
    mem_wdata <= wdata_d;
  end

  // Load bookkeeping that follows the read through the RAM latency
  always_ff @(posedge clk) begin
    if (rst) lat_q[0] <= '0;
    else     lat_q[0] <= meta_d;
  end

  for (genvar k = 1; k <= RD_LAT; k++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) lat_q[k] <= '0;
      else     lat_q[k] <= lat_q[k-1];
    end
  end

  imm_ldst_extract #(.DATA_W(DATA_W)) u_extract (
    .size(lat_q[RD_LAT].sz), .off(lat_q[RD_LAT].off),
    .rdata(mem_rdata), .value(ld_value)
  );

  always_ff @(posedge clk) begin
    if (rst) wb_valid <= 1'b0;
    else     wb_valid <= lat_q[RD_LAT].vld;
  end

  always_ff @(posedge clk) begin
    wb_reg  <= lat_q[RD_LAT].rd;
    wb_data <= ld_value;
  end

endmodule

// File: rtl/imm_ldst_unit_chk.sv
module imm_ldst_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_be,
  input logic              illegal_op,
  input logic              align_fault
);

  AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (mem_req || illegal_op || align_fault) |-> $past(req_valid)); // R1

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req, illegal_op, align_fault})); // R10

  AST_FAULT_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> !align_fault); // R6

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                 (&mem_be))); // R7

  AST_BYTE_LANE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $countones(mem_be) == 1) |-> mem_be[mem_addr[LANE_BITS-1:0]]); // R7

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && (&mem_be)) |-> (mem_addr[LANE_BITS-1:0] == '0)); // R6

  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $countones(mem_be) == 2) |-> !mem_addr[0]); // R6

endmodule

bind imm_ldst_unit imm_ldst_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_be(mem_be), .illegal_op(illegal_op),
  .align_fault(align_fault)
);

// File: tb/imm_ldst_unit_test.sv
`timescale 1ns/1ps
module imm_ldst_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0, req_sp_base = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [3:0]  req_rt = '0, req_rn = '0;
  logic [31:0] req_base = '0, req_wdata = '0;
  logic [9:0]  req_imm = '0;
  logic        mem_req, mem_we, wb_valid, illegal_op, align_fault;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_be;
  logic [2:0]  wb_reg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] bmem [64];

  always #2 clk = ~clk;

  imm_ldst_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_sp_base(req_sp_base), .req_rt(req_rt),
    .req_rn(req_rn), .req_base(req_base), .req_imm(req_imm),
    .req_wdata(req_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .wb_data(wb_data), .illegal_op(illegal_op), .align_fault(align_fault)
  );

  // Bench RAM: one-cycle synchronous read, lane-masked write
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) bmem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= bmem[mem_addr[7:2]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drives one request at a falling edge, returns the issue-stage outputs
  // and the write-back outputs two cycles later.
  task automatic issue(input logic st, input logic [1:0] sz, input logic sp,
                       input logic [3:0] rt, input logic [3:0] rn,
                       input logic [31:0] base, input logic [9:0] imm,
                       input logic [31:0] wd,
                       output logic o_req, output logic [31:0] o_addr,
                       output logic [3:0] o_be, output logic [31:0] o_wd,
                       output logic o_ill, output logic o_flt,
                       output logic o_wbv, output logic [2:0] o_wbr,
                       output logic [31:0] o_wbd);
    req_valid = 1'b1; req_store = st; req_size = sz; req_sp_base = sp;
    req_rt = rt; req_rn = rn; req_base = base; req_imm = imm; req_wdata = wd;
    @(negedge clk);
    o_req = mem_req; o_addr = mem_addr; o_be = mem_be; o_wd = mem_wdata;
    o_ill = illegal_op; o_flt = align_fault;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    o_wbv = wb_valid; o_wbr = wb_reg; o_wbd = wb_data;
  endtask

  logic        r_req, r_ill, r_flt, r_wbv;
  logic [31:0] r_addr, r_wd, r_wbd;
  logic [3:0]  r_be;
  logic [2:0]  r_wbr;

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 mem_req in reset", {31'b0, mem_req}, 32'd0);
    chk("R11 wb_valid in reset", {31'b0, wb_valid}, 32'd0);
    chk("R11 faults in reset", {30'b0, illegal_op, align_fault}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 quiet after reset", {28'b0, mem_req, wb_valid, illegal_op, align_fault}, 32'd0);
  endtask

  task automatic t_word_roundtrip();
    issue(1, 2'b10, 0, 4'd2, 4'd5, 32'h40, 10'd8, 32'hDEADBEEF,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R1 word store strobe", {31'b0, r_req}, 32'd1);
    chk("R1 word store address", r_addr, 32'h48);
    chk("R7 word enables", {28'b0, r_be}, 32'hF);
    chk("R8 word written", bmem[6'h12], 32'hDEADBEEF);
    chk("R9 no wb for store", {31'b0, r_wbv}, 32'd0);
    issue(0, 2'b10, 0, 4'd6, 4'd1, 32'h48, 10'd0, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R1 zero offset addresses base", r_addr, 32'h48);
    chk("R9 word load wb_valid", {31'b0, r_wbv}, 32'd1);
    chk("R9 word load wb_reg", {29'b0, r_wbr}, 32'd6);
    chk("R9 word load data", r_wbd, 32'hDEADBEEF);
    @(negedge clk);
    chk("R9 wb_valid single cycle", {31'b0, wb_valid}, 32'd0);
  endtask

  task automatic t_sp_word_bounds();
    issue(0, 2'b10, 1, 4'd0, 4'd0, 32'h100, 10'd1020, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R2 sp word 1020 accepted", {30'b0, r_req, r_ill}, 32'h2);
    chk("R2 sp word 1020 address", r_addr, 32'h4FC);
    issue(0, 2'b10, 1, 4'd0, 4'd0, 32'h100, 10'd1022, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R2 sp word 1022 rejected", {30'b0, r_req, r_ill}, 32'h1);
    issue(0, 2'b10, 1, 4'd0, 4'd0, 32'h100, 10'd1023, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R2 sp word 1023 rejected", {30'b0, r_req, r_ill}, 32'h1);
    chk("R10 no wb after illegal", {31'b0, r_wbv}, 32'd0);
  endtask

  task automatic t_reg_word_bounds();
    issue(0, 2'b10, 0, 4'd1, 4'd7, 32'h0, 10'd124, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R3 reg word 124 accepted", {30'b0, r_req, r_ill}, 32'h2);
    issue(0, 2'b10, 0, 4'd1, 4'd7, 32'h0, 10'd128, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R3 reg word 128 rejected", {30'b0, r_req, r_ill}, 32'h1);
    issue(1, 2'b10, 0, 4'd1, 4'd7, 32'h0, 10'd122, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R3 reg word 122 rejected", {30'b0, r_req, r_ill}, 32'h1);
  endtask

  task automatic t_subword_bounds();
    issue(0, 2'b01, 0, 4'd1, 4'd2, 32'h0, 10'd62, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R4 half 62 accepted", {30'b0, r_req, r_ill}, 32'h2);
    issue(0, 2'b01, 0, 4'd1, 4'd2, 32'h0, 10'd64, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R4 half 64 rejected", {30'b0, r_req, r_ill}, 32'h1);
    issue(0, 2'b01, 0, 4'd1, 4'd2, 32'h0, 10'd61, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R4 half odd offset rejected", {30'b0, r_req, r_ill}, 32'h1);
    issue(0, 2'b00, 0, 4'd1, 4'd2, 32'h0, 10'd31, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R4 byte 31 accepted", {30'b0, r_req, r_ill}, 32'h2);
    issue(0, 2'b00, 0, 4'd1, 4'd2, 32'h0, 10'd32, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R4 byte 32 rejected", {30'b0, r_req, r_ill}, 32'h1);
    issue(0, 2'b00, 1, 4'd1, 4'd2, 32'h0, 10'd0, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R4 byte on sp rejected", {30'b0, r_req, r_ill}, 32'h1);
    issue(0, 2'b01, 1, 4'd1, 4'd2, 32'h0, 10'd0, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R4 half on sp rejected", {30'b0, r_req, r_ill}, 32'h1);
    issue(0, 2'b11, 0, 4'd1, 4'd2, 32'h0, 10'd0, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R4 reserved size rejected", {30'b0, r_req, r_ill}, 32'h1);
  endtask

  task automatic t_reg_index();
    issue(0, 2'b10, 0, 4'd8, 4'd0, 32'h0, 10'd0, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R5 rt 8 rejected", {30'b0, r_req, r_ill}, 32'h1);
    issue(0, 2'b10, 0, 4'd3, 4'd9, 32'h0, 10'd0, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R5 rn 9 rejected", {30'b0, r_req, r_ill}, 32'h1);
    issue(0, 2'b10, 1, 4'd3, 4'd9, 32'h0, 10'd0, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R5 rn ignored with sp base", {30'b0, r_req, r_ill}, 32'h2);
  endtask

  task automatic t_alignment();
    issue(0, 2'b10, 0, 4'd1, 4'd1, 32'h41, 10'd0, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R6 word misaligned faults", {29'b0, r_req, r_ill, r_flt}, 32'h1);
    chk("R10 no wb after fault", {31'b0, r_wbv}, 32'd0);
    issue(1, 2'b01, 0, 4'd1, 4'd1, 32'h43, 10'd2, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R6 half misaligned faults", {29'b0, r_req, r_ill, r_flt}, 32'h1);
    issue(0, 2'b00, 0, 4'd1, 4'd1, 32'h43, 10'd2, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R6 byte never misaligned", {29'b0, r_req, r_ill, r_flt}, 32'h4);
    issue(0, 2'b10, 0, 4'd1, 4'd1, 32'h41, 10'd2, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R6 illegal beats misalign", {29'b0, r_req, r_ill, r_flt}, 32'h2);
  endtask

  task automatic t_subword_store();
    bmem[6'h14] = 32'hAABBCCDD;
    bmem[6'h15] = 32'h11223344;
    issue(1, 2'b00, 0, 4'd4, 4'd0, 32'h50, 10'd2, 32'h12345678,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R7 byte lane 2 enable", {28'b0, r_be}, 32'h4);
    chk("R8 byte store merges", bmem[6'h14], 32'hAA78CCDD);
    issue(1, 2'b01, 0, 4'd4, 4'd0, 32'h50, 10'd6, 32'hCAFEBEEF,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R7 upper half enables", {28'b0, r_be}, 32'hC);
    chk("R8 half store merges", bmem[6'h15], 32'hBEEF3344);
    issue(1, 2'b01, 0, 4'd4, 4'd0, 32'h50, 10'd4, 32'h00005566,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R7 lower half enables", {28'b0, r_be}, 32'h3);
    chk("R8 lower half merges", bmem[6'h15], 32'hBEEF5566);
  endtask

  task automatic t_subword_load();
    issue(0, 2'b00, 0, 4'd7, 4'd3, 32'h50, 10'd3, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R9 byte lane 3 load", r_wbd, 32'h000000AA);
    chk("R9 byte load wb_reg", {29'b0, r_wbr}, 32'd7);
    issue(0, 2'b00, 0, 4'd0, 4'd3, 32'h50, 10'd0, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R9 byte zero extended", r_wbd, 32'h000000DD);
    issue(0, 2'b01, 0, 4'd5, 4'd3, 32'h50, 10'd4, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R9 low half load", r_wbd, 32'h00005566);
    issue(0, 2'b01, 0, 4'd5, 4'd3, 32'h50, 10'd6, 32'h0,
          r_req, r_addr, r_be, r_wd, r_ill, r_flt, r_wbv, r_wbr, r_wbd);
    chk("R9 high half zero extended", r_wbd, 32'h0000BEEF);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = '0;
    @(negedge clk);
    t_reset();
    t_word_roundtrip();
    t_sp_word_bounds();
    t_reg_word_bounds();
    t_subword_bounds();
    t_reg_index();
    t_alignment();
    t_subword_store();
    t_subword_load();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule